// File: doc/BRIEF.md
# Display Clock Divide-and-Squash Chain

This block derives a slower display-domain timing strobe from a fast reference clock. Pulses travel as single-cycle clock enables, never as gated clocks. A qualifying enable on `ref_en_i` passes through three stages in series:

1. A power-of-two divider, whose divisor is chosen by a small code.
2. A pattern-driven squasher, which deletes individual pulses wherever its bit pattern holds a zero.
3. A fixed halving stage, which drives a toggling clock-like output and a strobe.

The long-run output rate is `ref_rate / D * (ones / len) / 2`. This allows non-integer ratios that no plain integer divider could give.

Either of the first two stages can be left out at elaboration time, or bypassed at run time. A bypassed stage passes every pulse through. New divisor codes and new patterns are applied only at stage boundaries, so a frequency change never produces a half-applied setting. The reset is synchronous and active-low.

Top module: `cdclk_chain`

## Requirements
- R1: While `rst_n` is low at a clock edge, the divide counter, the pattern index and the toggle output are cleared. After that edge, `cd_en_o` and `cd_clk_o` read 0.
- R2: With the squasher bypassed, divisor code `div_sel_i` = 0, 1, 2, 3 selects divide-by 1, 2, 4 or 8. The divider passes the Nth, 2Nth, ... qualifying reference pulse after reset.
- R3: A change of `div_sel_i` takes effect only when the current divide count completes.
- R4: The squasher consumes one pattern bit per pulse it receives, starting at bit 0 (the LSB). A 1 passes the pulse and a 0 removes it. After bit `len-1` the index wraps to bit 0.
- R5: `sq_wave_i` and `sq_len_i` are captured only at the wrap point (and in reset or bypass), never part way through a pattern.
- R6: If the pattern bits inside the active length are all zero, the squasher passes every pulse.
- R7: The final stage inverts `cd_clk_o` one cycle after each surviving pulse. On every second surviving pulse, counted from reset, it raises `cd_en_o` for one cycle, at the same edge where `cd_clk_o` falls.
- R8: With `div_bypass_i` high, the divider passes each pulse unchanged and restarts its count.
- R9: With `sq_bypass_i` high, the squasher passes each pulse unchanged and restarts at bit 0.
- R10: Over `2*D*len` reference pulses after reset, exactly as many `cd_en_o` strobes appear as there are one bits in the active pattern (or `len` when the squasher passes everything).
- R11: In a cycle where `ref_en_i` is low, no stage advances: `cd_clk_o` holds and `cd_en_o` stays low.
- R12: `sq_len_i` values 1 to 16 select that pattern length. The values 0 and 17 to 31 select 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_en_i | input | 1 | Qualifying reference pulse (clock enable) |
| div_sel_i | input | 2 | Divisor code: 0..3 gives divide-by 1, 2, 4, 8 |
| div_bypass_i | input | 1 | Divider pass-through |
| sq_wave_i | input | 16 | Squash pattern, bit 0 used first |
| sq_len_i | input | 5 | Pattern length 1..16 (0 or above 16 selects 16) |
| sq_bypass_i | input | 1 | Squasher pass-through |
| cd_en_o | output | 1 | Output strobe, one per two surviving pulses |
| cd_clk_o | output | 1 | Toggling clock-like output |

## Verification
The bench sweeps every divisor code against every pattern length and three patterns. One of these patterns leaves only the high bit set, so the shorter lengths see an all-zero pattern. Each run is compared cycle by cycle against an arithmetic pulse-position model, and the strobe total is compared against the rate formula.

Each corner case targets a specific error:
- An index that wraps one bit late or early would shift every squashed slot.
- A divisor applied mid-count would move the first output pulse.
- A pattern loaded before the wrap would let a pulse through where the old pattern still holds a zero.
- A length of 0 decoded literally would stall the chain.

Sparse reference enables catch a stage that advances on idle cycles.

// File: rtl/cdclk_chain_pkg.sv
// Package: cdclk_chain_pkg
// Shared widths for the divide-and-squash chain. All derived sizes come
// from SEL_W and WAVE_W so the stage modules stay consistent.
package cdclk_chain_pkg;
    // Width of the divisor code; the divisor is 2**code.
    localparam int SEL_W  = 2;
    // Width of the squash pattern register.
    localparam int WAVE_W = 16;
    // Width needed to hold a pattern length of 1..WAVE_W.
    localparam int LEN_W  = $clog2(WAVE_W + 1);
    // Width of the pattern index.
    localparam int IDX_W  = $clog2(WAVE_W);
    // Largest divisor exponent, and the counter width that holds 2**max - 1.
    localparam int CNT_W  = (1 << SEL_W) - 1;
endpackage

// File: rtl/cdclk_div.sv
// Module: cdclk_div
// Power-of-two pulse divider. Passes the Nth qualifying enable, where
// N = 2**code. The code is sampled into an active register only when a
// divide count completes (or in reset/bypass), so a new code never
// shortens or lengthens the period already in progress.
// Assumes: CNT_W >= 2**SEL_W - 1 so the largest count fits.
module cdclk_div #(
    parameter int SEL_W = 2,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_en,
    input  logic             bypass,
    input  logic [SEL_W-1:0] sel,
    output logic             out_en
);
    logic [SEL_W-1:0] cur_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   span;
    logic [CNT_W-1:0] lim;
    logic             done;

    // Terminal count of the active divisor and completion detect.
    always_comb begin
        span   = (CNT_W+1)'(1) << cur_q;
        lim    = CNT_W'(span - 1'b1);
        done   = in_en && (cnt_q == lim);
        out_en = bypass ? in_en : done;
    end

    // Count qualifying pulses; reload the divisor code only at completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            cur_q <= sel;
        end else if (bypass) begin
            cnt_q <= '0;
            cur_q <= sel;
        end else if (in_en) begin
            if (done) begin
                cnt_q <= '0;
                cur_q <= sel;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    AST_DIV_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && !done) |=> $stable(cur_q)); // R3

    AST_DIV_OUT_NEEDS_IN: assert property (@(posedge clk) disable iff (!rst_n)
        out_en |-> in_en); // R2
endmodule

// File: rtl/cdclk_squash.sv
// Module: cdclk_squash
// Pattern-driven pulse remover. Each incoming enable consumes one bit of
// the active pattern, starting at bit 0; a 1 passes the pulse, a 0 drops
// it. The pattern and its length are captured together at the wrap point
// only. An active pattern with no ones inside its length is treated as
// illegal and the stage passes every pulse instead of stalling.
// Assumes: length code 0 or above WAVE_W means WAVE_W.
module cdclk_squash #(
    parameter int WAVE_W = 16,
    parameter int LEN_W  = 5,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_en,
    input  logic              bypass,
    input  logic [WAVE_W-1:0] wave,
    input  logic [LEN_W-1:0]  len,
    output logic              out_en
);
    logic [WAVE_W-1:0] act_wave_q;
    logic [LEN_W-1:0]  act_len_q;
    logic [IDX_W-1:0]  idx_q;
    logic [LEN_W-1:0]  eff_len;
    logic [LEN_W-1:0]  last;
    logic [WAVE_W-1:0] mask;
    logic              all_zero;
    logic              wrap;

    // Decode the effective length, used-bit mask and the illegal pattern case.
    always_comb begin
        if (act_len_q == '0 || act_len_q > LEN_W'(WAVE_W))
            eff_len = LEN_W'(WAVE_W);
        else
            eff_len = act_len_q;
        last = eff_len - 1'b1;
        for (int i = 0; i < WAVE_W; i++)
            mask[i] = (LEN_W'(i) < eff_len);
        all_zero = ~|(act_wave_q & mask);
        wrap     = in_en && (LEN_W'(idx_q) == last);
        out_en   = in_en && (bypass || all_zero || act_wave_q[idx_q]);
    end

    // Step the pattern index per pulse; capture pattern and length at wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || bypass) begin
            idx_q      <= '0;
            act_wave_q <= wave;
            act_len_q  <= len;
        end else if (in_en) begin
            if (wrap) begin
                idx_q      <= '0;
                act_wave_q <= wave;
                act_len_q  <= len;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    AST_SQ_LOAD_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && !wrap) |=> ($stable(act_wave_q) && $stable(act_len_q))); // R5

    AST_SQ_OUT_NEEDS_IN: assert property (@(posedge clk) disable iff (!rst_n)
        out_en |-> in_en); // R4

    AST_SQ_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        LEN_W'(idx_q) < eff_len); // R4
endmodule

// File: rtl/cdclk_half.sv
// Module: cdclk_half
// Fixed divide-by-two stage. Inverts its clock-like output on every
// surviving enable and raises a one-cycle strobe on every second one,
// in the same cycle the output returns low.
// Assumes: input enables are single-cycle qualifiers of clk.
module cdclk_half (
    input  logic clk,
    input  logic rst_n,
    input  logic in_en,
    output logic clk_o,
    output logic en_o
);
    logic tog_q;
    logic en_q;

    // Toggle per surviving pulse; strobe when the toggle falls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tog_q <= 1'b0;
            en_q  <= 1'b0;
        end else begin
            en_q <= in_en && tog_q;
            if (in_en)
                tog_q <= ~tog_q;
        end
    end

    assign clk_o = tog_q;
    assign en_o  = en_q;

    AST_HALF_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        in_en |=> (tog_q != $past(tog_q))); // R7

    AST_HALF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_en |=> ($stable(tog_q) && !en_q)); // R11
endmodule

// File: rtl/cdclk_chain.sv
// Module: cdclk_chain
// Top of the divide-and-squash chain: divider, squasher, halver in
// series on clock enables. HAS_DIV / HAS_SQ remove a stage at
// elaboration; the bypass inputs pass a present stage through at run time.
// Assumes: ref_en_i is synchronous to clk.
module cdclk_chain
    import cdclk_chain_pkg::*;
#(
    parameter bit HAS_DIV = 1'b1,
    parameter bit HAS_SQ  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_en_i,
    input  logic [SEL_W-1:0]  div_sel_i,
    input  logic              div_bypass_i,
    input  logic [WAVE_W-1:0] sq_wave_i,
    input  logic [LEN_W-1:0]  sq_len_i,
    input  logic              sq_bypass_i,
    output logic              cd_en_o,
    output logic              cd_clk_o
);
    logic div_en;
    logic sq_en;

    // Optional selectable divider stage.
    generate
        if (HAS_DIV) begin : g_div
            cdclk_div #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_div (
                .clk    (clk),
                .rst_n  (rst_n),
                .in_en  (ref_en_i),
                .bypass (div_bypass_i),
                .sel    (div_sel_i),
                .out_en (div_en)
            );
        end else begin : g_no_div
            assign div_en = ref_en_i;
        end
    endgenerate

    // Optional squasher stage.
    generate
        if (HAS_SQ) begin : g_sq
            cdclk_squash #(.WAVE_W(WAVE_W), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_sq (
                .clk    (clk),
                .rst_n  (rst_n),
                .in_en  (div_en),
                .bypass (sq_bypass_i),
                .wave   (sq_wave_i),
                .len    (sq_len_i),
                .out_en (sq_en)
            );
        end else begin : g_no_sq
            assign sq_en = div_en;
        end
    endgenerate

    // Fixed halving stage, always present.
    cdclk_half u_half (
        .clk   (clk),
        .rst_n (rst_n),
        .in_en (sq_en),
        .clk_o (cd_clk_o),
        .en_o  (cd_en_o)
    );

    AST_EN_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        cd_en_o |-> (!cd_clk_o && $fell(cd_clk_o))); // R7

    AST_NO_REF_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_en_i |=> !cd_en_o); // R11
endmodule

// File: tb/cdclk_chain_bench.sv
module cdclk_chain_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_en_i = 1'b0;
    logic [1:0]  div_sel_i = 2'd0;
    logic        div_bypass_i = 1'b0;
    logic [15:0] sq_wave_i = 16'h0;
    logic [4:0]  sq_len_i = 5'd1;
    logic        sq_bypass_i = 1'b0;
    logic        cd_en_o;
    logic        cd_clk_o;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    cdclk_chain u_cdclk_chain (
        .clk          (clk),
        .rst_n        (rst_n),
        .ref_en_i     (ref_en_i),
        .div_sel_i    (div_sel_i),
        .div_bypass_i (div_bypass_i),
        .sq_wave_i    (sq_wave_i),
        .sq_len_i     (sq_len_i),
        .sq_bypass_i  (sq_bypass_i),
        .cd_en_o      (cd_en_o),
        .cd_clk_o     (cd_clk_o)
    );

    task automatic check(input string req, input bit ok, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reset with given settings held; checks the post-reset state (R1).
    task automatic do_reset();
        @(negedge clk);
        rst_n    = 1'b0;
        ref_en_i = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset", (cd_en_o === 1'b0) && (cd_clk_o === 1'b0),
              {cd_en_o, cd_clk_o}, 0);
    endtask

    // One configuration run, compared cycle by cycle against a pulse-position model.
    task automatic run_cfg(input logic [1:0] sel, input logic dbyp, input logic [15:0] wave,
                           input logic [4:0] len, input logic sbyp, input int gap,
                           input string req);
        int d, l, ones, k, c, m, strobes, bad_cyc, act_v, exp_v;
        logic tog, ex_en, zero, ok;
        logic [15:0] mask;
        d = dbyp ? 1 : (1 << sel);
        l = (len == 0 || len > 16) ? 16 : int'(len);
        for (int i = 0; i < 16; i++) mask[i] = (i < l);
        zero = ((wave & mask) == 16'h0);
        ones = (sbyp || zero) ? l : $countones(wave & mask);
        div_sel_i    = sel;
        div_bypass_i = dbyp;
        sq_wave_i    = wave;
        sq_len_i     = len;
        sq_bypass_i  = sbyp;
        do_reset();
        k = 0; c = 0; tog = 1'b0; strobes = 0; ok = 1'b1; bad_cyc = 0; act_v = 0; exp_v = 0;
        while (k < 2 * d * l) begin
            ref_en_i = ((c % gap) == 0);
            @(negedge clk);
            ex_en = 1'b0;
            if (ref_en_i) begin
                if (((k + 1) % d) == 0) begin
                    m = (((k + 1) / d) - 1) % l;
                    if (sbyp || zero || wave[m]) begin
                        ex_en = tog;
                        tog   = ~tog;
                    end
                end
                k++;
            end
            if (cd_en_o) strobes++;
            if (ok && ((cd_en_o !== ex_en) || (cd_clk_o !== tog))) begin
                ok = 1'b0; bad_cyc = c;
                act_v = {cd_en_o, cd_clk_o};
                exp_v = {ex_en, tog};
            end
            c++;
        end
        ref_en_i = 1'b0;
        check(req, ok, act_v, exp_v);
        if (!ok) $display("  first mismatch cycle=%0d sel=%0d len=%0d wave=%h", bad_cyc, sel, len, wave);
        check("R10 strobe count", strobes == ones, strobes, ones);
    endtask

    initial begin
        logic [15:0] pats [3];
        logic [1:0]  en_s [10];
        pats[0] = 16'hA5C3; pats[1] = 16'h8000; pats[2] = 16'h0001;

        // Sweep: divisor codes x lengths x patterns (R2 R4 R6 R7 R10).
        for (int s = 0; s < 4; s++)
            for (int ln = 1; ln <= 16; ln++)
                for (int p = 0; p < 3; p++)
                    run_cfg(2'(s), 1'b0, pats[p], 5'(ln), 1'b0, 1, "R2 R4 R6 R7 sweep");

        // Bypass paths (R8 R9), sparse enables (R11), length code decode (R12), zero pattern (R6).
        run_cfg(2'd3, 1'b1, 16'hB6D1, 5'd11, 1'b0, 1, "R8 divider bypass");
        run_cfg(2'd2, 1'b0, 16'h1234, 5'd7,  1'b1, 1, "R9 squasher bypass");
        run_cfg(2'd1, 1'b0, 16'h0F35, 5'd9,  1'b0, 3, "R11 sparse enables");
        run_cfg(2'd2, 1'b0, 16'h00F1, 5'd13, 1'b0, 2, "R11 sparse enables");
        run_cfg(2'd0, 1'b0, 16'h7E01, 5'd0,  1'b0, 1, "R12 length zero");
        run_cfg(2'd1, 1'b0, 16'h9C4B, 5'd23, 1'b0, 1, "R12 length over range");
        run_cfg(2'd1, 1'b0, 16'h0000, 5'd16, 1'b0, 1, "R6 zero pattern");

        // R3: divisor change mid-count applies only after the count completes.
        div_sel_i = 2'd3; div_bypass_i = 1'b0; sq_bypass_i = 1'b1;
        sq_wave_i = 16'hFFFF; sq_len_i = 5'd16;
        do_reset();
        for (int k = 0; k < 10; k++) begin
            if (k == 3) div_sel_i = 2'd0;
            ref_en_i = 1'b1;
            @(negedge clk);
            en_s[k] = {cd_en_o, cd_clk_o};
        end
        ref_en_i = 1'b0;
        check("R3 no early output", en_s[6] == 2'b00, en_s[6], 0);
        check("R3 first pulse at count 8", en_s[7] == 2'b01, en_s[7], 1);
        check("R3 new divisor after completion", en_s[8] == 2'b10, en_s[8], 2);

        // R5: pattern change mid-pattern loads only at the wrap.
        div_sel_i = 2'd0; sq_bypass_i = 1'b0; sq_wave_i = 16'h0001; sq_len_i = 5'd4;
        do_reset();
        for (int k = 0; k < 8; k++) begin
            if (k == 2) sq_wave_i = 16'h000F;
            ref_en_i = 1'b1;
            @(negedge clk);
            en_s[k] = {cd_en_o, cd_clk_o};
        end
        ref_en_i = 1'b0;
        check("R5 old pattern kept to wrap", en_s[3] == 2'b01, en_s[3], 1);
        check("R5 new pattern after wrap", en_s[4] == 2'b10, en_s[4], 2);
        check("R5 new pattern continues", en_s[6] == 2'b10, en_s[6], 2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule